// File: doc/BRIEF.md
# SEC-DED Memory ECC Datapath with Fault Log

This block sits between a host bus and a synchronous memory array that stores 72-bit words. On a host write, it reorders the 64 data bits into the fixed codec order and computes 8 check bits with a modified-Hamming (odd-column) code. It stores the data and check bits together in a single cycle. On a host read, it recomputes the check bits from the returned data and XORs them with the stored check bits to form a syndrome. It corrects any single-bit error, whether in a data or a check bit, and returns the data in bus order. It flags double-bit errors and odd-weight syndromes that match no column as uncorrectable.

The check-bit generator is a chain of four 16-bit slices. Each slice folds its partial parity into the running check vector. The first error after a clear is logged and held until a clear pulse. The log records the word address, the syndrome, the error kind and the bank index. For a single data-bit error, it also records the bus-order bit index, obtained through the inverse of the permutation. Any error that arrives while the log is full sets a sticky overflow flag.

Top module: `ecc_mem_ctrl`

## Requirements
- R1: A host write completes in one cycle. `mem_we` is high, and `mem_wdata[63:0]` carries the codec-order data. `mem_wdata[71:64]` carries the check bits, where check bit k is the XOR of every codec data bit j whose column has bit k set. The column of data bit j is the j-th 8-bit value of weight 3 in ascending order for j<56, and the (j-56)-th value of weight 5 in ascending order for j≥56. The column of check bit k is 1<<k.
- R2: Bus data bit b is stored at codec position {b[3:0],b[5:4]}, which is the 6-bit index rotated left by two.
- R3: A read strobe (`host_rd` high with `host_wr` low) raises `host_rvalid` in the next cycle. `host_rdata`, `host_ce` and `host_ue` are valid in that same cycle. When both strobes are high, only the write is performed and no read data follows.
- R4: A read whose syndrome is zero returns the stored bus-order data with `host_ce` and `host_ue` low.
- R5: Flipping any single one of the 72 stored bits yields the original data on `host_rdata`, with `host_ce` high and `host_ue` low.
- R6: Flipping any two stored bits gives `host_ue` high and `host_ce` low.
- R7: A nonzero syndrome that is odd in weight but equal to no column, such as one caused by some triple errors, gives `host_ue` high and `host_ce` low.
- R8: When the log is empty, the first flagged read sets `log_valid`. Starting in the cycle after the read data, the log shows the following values: the word address, the syndrome, the kind (`log_kind` 1 = correctable, 2 = uncorrectable) and `log_bank` = {addr[MSB], addr[MSB-1]}.
- R9: While `log_valid` is high and no clear is given, the log fields hold. A further flagged read sets `log_overflow`, and the flag stays high until a clear.
- R10: A `log_clr` pulse drops `log_valid` and `log_overflow` and sets `log_kind` to 0. If a flagged read is presented in the same cycle as the clear, that read is captured.
- R11: For a correctable error in a data bit, `log_bit_valid` is high and `log_bit` gives the bus-order index of the failing bit. For a check-bit error or an uncorrectable error, `log_bit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | 64 | Write data, bus order |
| host_rdata | output | 64 | Corrected read data, bus order |
| host_rvalid | output | 1 | Read data valid |
| host_ce | output | 1 | Correctable error on this read |
| host_ue | output | 1 | Uncorrectable error on this read |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 72 | Stored word: check bits over codec-order data |
| mem_rdata | input | 72 | Word returned one cycle after `mem_re` |
| log_clr | input | 1 | Clear the fault log |
| log_valid | output | 1 | Log holds an error |
| log_kind | output | 2 | 0 none, 1 correctable, 2 uncorrectable |
| log_addr | output | ADDR_W | Failing word address |
| log_syndrome | output | 8 | Syndrome of the logged error |
| log_bank | output | 2 | Major and minor bank index |
| log_overflow | output | 1 | Error lost while the log was full |
| log_bit | output | 6 | Bus-order index of a corrected data bit |
| log_bit_valid | output | 1 | `log_bit` is meaningful |

## Verification
The bench builds the block with the default ADDR_W of 10. This gives a 1024-word memory model in the bench, whose two top address bits select all four bank indices. With this size, every one of the 72 single-bit flips can be injected at one word, with a log clear between flips, so that the bus-order translation is checked for all 64 data positions. Double flips, odd-weight non-column triples, overflow and a clear that coincides with an error are driven at addresses spread across the banks.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W  = 64;
  localparam int CHK_W   = 8;
  localparam int CW_W    = DATA_W + CHK_W;
  localparam int IDX_W   = 6;
  localparam int SLICES  = 4;
  localparam int SLICE_W = DATA_W / SLICES;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CE   = 2'd1,
    ERR_UE   = 2'd2
  } err_kind_e;

  // Column table: weight-3 values ascending, then the first weight-5 values.
  function automatic logic [DATA_W-1:0][CHK_W-1:0] hsiao_table();
    logic [DATA_W-1:0][CHK_W-1:0] t;
    logic [6:0]       n;
    logic [CHK_W-1:0] v8;
    t = '0;
    n = '0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 0; v < 256; v++) begin
        v8 = v[CHK_W-1:0];
        if ($countones(v8) == w && n < 7'(DATA_W)) begin
          t[n[5:0]] = v8;
          n = n + 7'd1;
        end
      end
    end
    return t;
  endfunction

  function automatic logic [IDX_W-1:0] bus_to_codec(input logic [IDX_W-1:0] b);
    return {b[3:0], b[5:4]};
  endfunction

  function automatic logic [IDX_W-1:0] codec_to_bus(input logic [IDX_W-1:0] c);
    return {c[1:0], c[5:2]};
  endfunction

  function automatic logic [DATA_W-1:0] word_to_codec(input logic [DATA_W-1:0] bus);
    logic [DATA_W-1:0] c;
    c = '0;
    for (int b = 0; b < DATA_W; b++) c[bus_to_codec(IDX_W'(b))] = bus[b];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] word_to_bus(input logic [DATA_W-1:0] cd);
    logic [DATA_W-1:0] b;
    b = '0;
    for (int c = 0; c < DATA_W; c++) b[codec_to_bus(IDX_W'(c))] = cd[c];
    return b;
  endfunction
endpackage

// File: rtl/ecc_slice.sv
module ecc_slice
  import ecc_pkg::*;
#(
  parameter int SLICE = 0
) (
  input  logic [SLICE_W-1:0] d,
  input  logic [CHK_W-1:0]   chk_in,
  output logic [CHK_W-1:0]   chk_out
);
  localparam logic [DATA_W-1:0][CHK_W-1:0] COLS = hsiao_table();
  localparam int BASE = SLICE * SLICE_W;

  logic [CHK_W-1:0] part;

  always_comb begin
    part = '0;
    for (int i = 0; i < SLICE_W; i++) begin
      if (d[i]) part = part ^ COLS[BASE + i];
    end
  end

  assign chk_out = chk_in ^ part;
endmodule

// File: rtl/ecc_codec.sv
module ecc_codec
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] cdata,
  output logic [CHK_W-1:0]  chk
);
  logic [SLICES:0][CHK_W-1:0] chain;

  assign chain[0] = '0;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    ecc_slice #(.SLICE(s)) u_slice (
      .d      (cdata[s*SLICE_W +: SLICE_W]),
      .chk_in (chain[s]),
      .chk_out(chain[s+1])
    );
  end

  assign chk = chain[SLICES];
endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
  import ecc_pkg::*;
(
  input  logic [CW_W-1:0]   raw,
  output logic [CHK_W-1:0]  syndrome,
  output logic [DATA_W-1:0] fixed,
  output logic              ce,
  output logic              ue,
  output logic              data_hit,
  output logic [IDX_W-1:0]  hit_pos
);
  localparam logic [DATA_W-1:0][CHK_W-1:0] COLS = hsiao_table();

  logic [CHK_W-1:0]  calc;
  logic [DATA_W-1:0] match;
  logic              chk_hit;

  ecc_codec u_recalc (
    .cdata(raw[DATA_W-1:0]),
    .chk  (calc)
  );

  assign syndrome = raw[CW_W-1:DATA_W] ^ calc;

  always_comb begin
    for (int j = 0; j < DATA_W; j++) match[j] = (syndrome == COLS[j]);
  end

  always_comb begin
    hit_pos = '0;
    for (int j = 0; j < DATA_W; j++) begin
      if (match[j]) hit_pos = IDX_W'(j);
    end
  end

  assign chk_hit  = $onehot(syndrome);
  assign data_hit = |match;
  assign fixed    = raw[DATA_W-1:0] ^ match;
  assign ce       = data_hit | chk_hit;
  assign ue       = (syndrome != '0) & ~ce;
endmodule

// File: rtl/ecc_log.sv
module ecc_log
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt,
  input  err_kind_e         evt_kind,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [CHK_W-1:0]  evt_syn,
  input  logic              evt_bit_valid,
  input  logic [IDX_W-1:0]  evt_bit,
  output logic              valid,
  output err_kind_e         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [CHK_W-1:0]  syn,
  output logic [1:0]        bank,
  output logic              overflow,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              bit_valid
);
  logic capture;
  logic lost;

  assign capture = evt & (clr | ~valid);
  assign lost    = evt & valid & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      kind      <= ERR_NONE;
      addr      <= '0;
      syn       <= '0;
      bank      <= '0;
      overflow  <= 1'b0;
      bit_idx   <= '0;
      bit_valid <= 1'b0;
    end else begin
      if (capture) begin
        valid     <= 1'b1;
        kind      <= evt_kind;
        addr      <= evt_addr;
        syn       <= evt_syn;
        bank      <= evt_addr[ADDR_W-1 -: 2];
        bit_idx   <= evt_bit;
        bit_valid <= evt_bit_valid;
      end else if (clr) begin
        valid     <= 1'b0;
        kind      <= ERR_NONE;
        bit_valid <= 1'b0;
      end
      overflow <= clr ? 1'b0 : (overflow | lost);
    end
  end

  a_r8_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && evt) |=> valid);
  a_r9_log_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clr) |=> ($stable(addr) && $stable(syn) && $stable(kind) && $stable(bank)));
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> (!valid && !overflow));
  a_r11_bit_only_ce: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (kind == ERR_CE));
endmodule

// File: rtl/ecc_mem_ctrl.sv
module ecc_mem_ctrl
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              host_rvalid,
  output logic              host_ce,
  output logic              host_ue,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [71:0]       mem_wdata,
  input  logic [71:0]       mem_rdata,
  input  logic              log_clr,
  output logic              log_valid,
  output logic [1:0]        log_kind,
  output logic [ADDR_W-1:0] log_addr,
  output logic [7:0]        log_syndrome,
  output logic [1:0]        log_bank,
  output logic              log_overflow,
  output logic [5:0]        log_bit,
  output logic              log_bit_valid
);
  logic              rd_go;
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] wr_codec;
  logic [CHK_W-1:0]  wr_chk;
  logic [CHK_W-1:0]  dec_syn;
  logic [DATA_W-1:0] dec_fixed;
  logic              dec_ce;
  logic              dec_ue;
  logic              dec_data_hit;
  logic [IDX_W-1:0]  dec_pos;
  logic              err_evt;
  err_kind_e         err_kind;
  err_kind_e         log_kind_e;

  assign rd_go     = host_rd & ~host_wr;
  assign mem_we    = host_wr;
  assign mem_re    = rd_go;
  assign mem_addr  = host_addr;
  assign wr_codec  = word_to_codec(host_wdata);

  ecc_codec u_gen (
    .cdata(wr_codec),
    .chk  (wr_chk)
  );

  assign mem_wdata = {wr_chk, wr_codec};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_pend <= rd_go;
      if (rd_go) rd_addr_q <= host_addr;
    end
  end

  ecc_decode u_dec (
    .raw     (mem_rdata),
    .syndrome(dec_syn),
    .fixed   (dec_fixed),
    .ce      (dec_ce),
    .ue      (dec_ue),
    .data_hit(dec_data_hit),
    .hit_pos (dec_pos)
  );

  assign host_rvalid = rd_pend;
  assign host_rdata  = word_to_bus(dec_fixed);
  assign host_ce     = rd_pend & dec_ce;
  assign host_ue     = rd_pend & dec_ue;
  assign err_evt     = host_ce | host_ue;
  assign err_kind    = dec_ue ? ERR_UE : ERR_CE;

  ecc_log #(.ADDR_W(ADDR_W)) u_log (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (log_clr),
    .evt          (err_evt),
    .evt_kind     (err_kind),
    .evt_addr     (rd_addr_q),
    .evt_syn      (dec_syn),
    .evt_bit_valid(dec_data_hit & ~dec_ue),
    .evt_bit      (codec_to_bus(dec_pos)),
    .valid        (log_valid),
    .kind         (log_kind_e),
    .addr         (log_addr),
    .syn          (log_syndrome),
    .bank         (log_bank),
    .overflow     (log_overflow),
    .bit_idx      (log_bit),
    .bit_valid    (log_bit_valid)
  );

  assign log_kind = log_kind_e;

  a_r3_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> host_rvalid);
  a_r3_no_read_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> !host_rvalid);
  a_r4_zero_syn_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && dec_syn == '0) |-> (!host_ce && !host_ue));
  a_r6_even_syn_ue: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && dec_syn != '0 && !(^dec_syn)) |-> (host_ue && !host_ce));
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ce && host_ue));
endmodule

// File: tb/test_ecc_mem_ctrl.sv
`timescale 1ns/1ps
module test_ecc_mem_ctrl;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [63:0]   host_wdata = '0;
  logic [63:0]   host_rdata;
  logic          host_rvalid, host_ce, host_ue;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [71:0]   mem_wdata;
  logic [71:0]   mem_rdata = '0;
  logic          log_clr = 1'b0;
  logic          log_valid, log_overflow, log_bit_valid;
  logic [1:0]    log_kind, log_bank;
  logic [AW-1:0] log_addr;
  logic [7:0]    log_syndrome;
  logic [5:0]    log_bit;

  logic [71:0]   mem [0:(1<<AW)-1];
  logic [AW-1:0] inj_addr = '0;
  logic [71:0]   inj_mask = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecc_mem_ctrl #(.ADDR_W(AW)) i_ecc_mem_ctrl (.*);

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr] ^ ((mem_addr == inj_addr) ? inj_mask : 72'd0);
  end

  function automatic logic [7:0] t_col(input int j);
    int n = 0;
    logic [7:0] r = 8'd0;
    if (j < 56) begin
      for (int c = 2; c < 8; c++)
        for (int b = 1; b < c; b++)
          for (int a = 0; a < b; a++) begin
            if (n == j) r = 8'((1 << a) | (1 << b) | (1 << c));
            n++;
          end
    end else begin
      n = 56;
      for (int v = 0; v < 256; v++)
        if ($countones(8'(v)) == 5) begin
          if (n == j) r = 8'(v);
          n++;
        end
    end
    return r;
  endfunction

  function automatic int t_perm(input int b);
    return (b == 63) ? 63 : (b * 4) % 63;
  endfunction

  function automatic int t_unperm(input int c);
    return (c == 63) ? 63 : (c * 16) % 63;
  endfunction

  function automatic logic [71:0] t_encode(input logic [63:0] bus);
    logic [63:0] cd = 64'd0;
    logic [7:0]  ck = 8'd0;
    for (int b = 0; b < 64; b++) cd[t_perm(b)] = bus[b];
    for (int j = 0; j < 64; j++) if (cd[j]) ck = ck ^ t_col(j);
    return {ck, cd};
  endfunction

  function automatic bit t_is_col(input logic [7:0] s);
    if ($countones(s) == 1) return 1'b1;
    for (int j = 0; j < 64; j++) if (t_col(j) == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [63:0] d, output logic ce, output logic ue, output logic rv);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0;
    d = host_rdata; ce = host_ce; ue = host_ue; rv = host_rvalid;
  endtask

  task automatic do_clear();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  initial begin
    logic [63:0]   d, rd;
    logic          ce, ue, rv;
    logic [AW-1:0] a;
    logic [63:0]   tdat [0:23];
    logic [AW-1:0] tadr [0:23];
    logic [71:0]   m;
    logic [7:0]    s;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    chk(host_rvalid == 1'b0 && log_valid == 1'b0 && log_overflow == 1'b0 && log_kind == 2'd0,
        "R8 reset state", {log_valid, log_overflow, host_rvalid}, 72'd0);
    rst_n = 1'b1;

    // R1 R2: writes store the expected encoded word
    for (int i = 0; i < 24; i++) begin
      tadr[i] = AW'(i * 41 + 3);
      tdat[i] = {$urandom, $urandom};
      if (i == 0) tdat[i] = 64'd0;
      if (i == 1) tdat[i] = '1;
      do_write(tadr[i], tdat[i]);
      chk(mem[tadr[i]] == t_encode(tdat[i]), "R1 R2 stored codeword", mem[tadr[i]], t_encode(tdat[i]));
    end

    // R3 R4: clean reads
    for (int i = 0; i < 24; i++) begin
      do_read(tadr[i], rd, ce, ue, rv);
      chk(rv == 1'b1, "R3 rvalid one cycle after strobe", 72'(rv), 72'd1);
      chk(rd == tdat[i] && !ce && !ue, "R4 clean read", {ce, ue, rd}, {2'b00, tdat[i]});
    end
    @(negedge clk);
    chk(log_valid == 1'b0, "R4 no log on clean reads", 72'(log_valid), 72'd0);

    // R5 R8 R11: every single-bit flip at one word
    a = tadr[5];
    for (int p = 0; p < 72; p++) begin
      inj_addr = a; inj_mask = 72'd1 << p;
      do_read(a, rd, ce, ue, rv);
      chk(rd == tdat[5] && ce && !ue, "R5 single flip corrected", {ce, ue, rd}, {2'b10, tdat[5]});
      @(negedge clk);
      s = (p < 64) ? t_col(p) : 8'(1 << (p - 64));
      chk(log_valid && log_kind == 2'd1 && log_addr == a && log_syndrome == s,
          "R8 log capture single", {log_kind, log_addr, log_syndrome}, {2'd1, a, s});
      chk(log_bank == {a[AW-1], a[AW-2]}, "R8 bank index", 72'(log_bank), 72'({a[AW-1], a[AW-2]}));
      if (p < 64)
        chk(log_bit_valid && log_bit == 6'(t_unperm(p)), "R11 bus bit index",
            {log_bit_valid, log_bit}, {1'b1, 6'(t_unperm(p))});
      else
        chk(!log_bit_valid, "R11 no bit index for check bit", 72'(log_bit_valid), 72'd0);
      do_clear();
    end

    // R6: double flips at spread addresses
    for (int i = 0; i < 20; i++) begin
      int p1, p2;
      p1 = int'($urandom % 72);
      p2 = (p1 + 1 + int'($urandom % 71)) % 72;
      a = tadr[i];
      inj_addr = a; inj_mask = (72'd1 << p1) | (72'd1 << p2);
      do_read(a, rd, ce, ue, rv);
      chk(ue && !ce, "R6 double flip uncorrectable", {ce, ue}, 72'b01);
      @(negedge clk);
      chk(log_kind == 2'd2 && log_addr == a && !log_bit_valid && log_bank == {a[AW-1], a[AW-2]},
          "R8 R11 log of double", {log_kind, log_bit_valid, log_addr}, {2'd2, 1'b0, a});
      do_clear();
    end

    // R7: triples whose syndrome is odd and matches no column
    begin
      int found = 0;
      for (int t = 0; t < 400 && found < 10; t++) begin
        int p1, p2, p3;
        p1 = int'($urandom % 64); p2 = int'($urandom % 64); p3 = int'($urandom % 64);
        s = t_col(p1) ^ t_col(p2) ^ t_col(p3);
        if (p1 != p2 && p2 != p3 && p1 != p3 && !t_is_col(s)) begin
          found++;
          a = tadr[found];
          inj_addr = a; inj_mask = (72'd1 << p1) | (72'd1 << p2) | (72'd1 << p3);
          do_read(a, rd, ce, ue, rv);
          chk(ue && !ce, "R7 odd non-column syndrome uncorrectable", {ce, ue}, 72'b01);
          @(negedge clk);
          chk(log_syndrome == s, "R7 logged syndrome", 72'(log_syndrome), 72'(s));
          do_clear();
        end
      end
      chk(found == 10, "R7 triple cases found", 72'(found), 72'd10);
    end

    // R9: overflow while full, fields held
    inj_addr = tadr[2]; inj_mask = 72'd1 << 7;
    do_read(tadr[2], rd, ce, ue, rv);
    inj_addr = tadr[20]; inj_mask = 72'd3;
    do_read(tadr[20], rd, ce, ue, rv);
    @(negedge clk);
    chk(log_overflow && log_addr == tadr[2] && log_kind == 2'd1, "R9 overflow and hold",
        {log_overflow, log_kind, log_addr}, {1'b1, 2'd1, tadr[2]});
    repeat (3) @(negedge clk);
    chk(log_overflow, "R9 overflow sticky", 72'(log_overflow), 72'd1);

    // R10: clear
    do_clear();
    chk(!log_valid && !log_overflow && log_kind == 2'd0, "R10 clear empties log",
        {log_valid, log_overflow, log_kind}, 72'd0);

    // R10: clear in the same cycle as a flagged read captures it
    inj_addr = tadr[3]; inj_mask = 72'd1 << 40;
    do_read(tadr[3], rd, ce, ue, rv);
    inj_addr = tadr[9]; inj_mask = 72'd5;
    @(negedge clk); host_rd = 1'b1; host_addr = tadr[9];
    @(negedge clk); host_rd = 1'b0; log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    chk(log_valid && log_addr == tadr[9] && log_kind == 2'd2 && !log_overflow,
        "R10 clear with simultaneous error", {log_valid, log_overflow, log_kind, log_addr},
        {1'b1, 1'b0, 2'd2, tadr[9]});
    do_clear();
    inj_mask = 72'd0;

    // R3: write has priority over a simultaneous read
    d = {$urandom, $urandom};
    a = 10'h3F0;
    @(negedge clk); host_wr = 1'b1; host_rd = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0; host_rd = 1'b0;
    chk(!host_rvalid, "R3 no read data when write wins", 72'(host_rvalid), 72'd0);
    chk(mem[a] == t_encode(d), "R3 R1 write performed", mem[a], t_encode(d));
    do_read(a, rd, ce, ue, rv);
    chk(rd == d && rv && !ce && !ue, "R4 readback after priority write", {rv, ce, ue, rd}, {3'b100, d});

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule